// File: doc/BRIEF.md
# Indexed Configuration Register Port

The block is a small bank of configuration bytes reached through two byte addresses on an 8-bit I/O bus. Software first writes a register number to the even address. It then reads or writes the selected byte through the odd address. Twenty-five bytes exist, numbered 0xE0 through 0xF8. A few of them cannot be written. Several have bits that a write always clears or always sets. The whole bank is also driven out as one wide vector, so that downstream address-decode and routing logic can use it without going through the bus.

An enable bit in an external bridge configuration byte turns the port on or off. While the port is off it ignores every strobe and drives zero on the read bus. When software selects a number outside the implemented range, a read of the odd address returns the most recent byte that crossed the port. That byte is either the last one written or the last one read.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the selected register number is 0x00, the register at 0xE0 holds 0x3C, the one at 0xE2 holds 0x03, every other register holds 0x00, and the recorded last byte is 0x00.
- R2: A write to address BASE (address bit 0 clear) loads the written byte as the selected register number, whatever its value.
- R3: A write to address BASE+1 while the selected number lies in 0xE0..0xF8 stores the masked byte into the register numbered by the low 5 bits of the selected number.
- R4: A write to BASE+1 while the selected number is outside 0xE0..0xF8 leaves every register unchanged.
- R5: Registers 0xE0, 0xE1 and 0xEC never change on a write.
- R6: Stored values are shaped per register: 0xE2 clears bit 6; 0xE3 and 0xE4 clear bits 1:0; 0xE5 sets bits 1:0; 0xE7, 0xE8, 0xF4 and 0xF7 clear bit 0; 0xED keeps bits 3:0; 0xEF clears bit 7; 0xF0 keeps bits 7:4 and 2; 0xF1 keeps bits 5:0; 0xF3 clears bit 2; 0xF6 clears bit 3. All other writable registers store the byte unchanged.
- R7: A read of BASE returns the selected register number, with no delay on the read strobe.
- R8: A read of BASE+1 with a selected number in 0xE0..0xF8 returns that register's content.
- R9: Every accepted write, to either address, records its byte as the last byte. Every read of BASE records the selected number, and every read of BASE+1 with a valid selection records the returned byte. A read of BASE+1 with an invalid selection returns the recorded last byte.
- R10: While bit 1 of the bridge configuration byte is 0, the read bus is 0x00 and no strobe changes any state.
- R11: Addresses other than BASE and BASE+1 are ignored, and the read bus stays 0x00 for them.
- R12: The image output carries register 0xE0+k in bits 8k+7..8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| bridge_cfg_i | input | 8 | Bridge configuration byte; bit 1 enables the port |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | Single-cycle write strobe |
| io_rd_i | input | 1 | Single-cycle read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational on the read strobe, 0x00 when not selected |
| cfg_image_o | output | 200 | All 25 registers, 0xE0 in the lowest byte |

## Verification
Directed sequences first write each shaped register with 0x00 and with 0xFF. This separates forced-high bits from cleared bits and shows whether a read-only register moved. A selection outside the range, followed by an odd read, tells echo of the last write apart from echo of the last read. Toggling the enable bit and using neighbouring addresses show that disabled and off-address cycles change nothing. A long seeded random mix of valid and invalid selections, reads and writes is then compared against a bench model of the whole bank and of the last byte after every operation.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int NREG     = 25;
  localparam int BYTE_W   = 8;
  localparam int IMG_W    = NREG * BYTE_W;
  localparam int SLOT_W   = 5;
  localparam logic [2:0] IDX_HI = 3'b111;

  // Slots that software cannot modify.
  function automatic logic slot_is_ro(input int slot);
    return (slot == 0) || (slot == 1) || (slot == 12);
  endfunction

  function automatic logic [7:0] slot_rst(input int slot);
    case (slot)
      0:       return 8'h3C;
      2:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_and(input int slot);
    case (slot)
      2:              return 8'hBF;
      3, 4:           return 8'hFC;
      7, 8, 20, 23:   return 8'hFE;
      13:             return 8'h0F;
      15:             return 8'h7F;
      16:             return 8'hF4;
      17:             return 8'h3F;
      19:             return 8'hFB;
      22:             return 8'hF7;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slot_or(input int slot);
    return (slot == 5) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h03F0,
  parameter int              EN_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [7:0]        bridge_cfg_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic              sel_o,
  output logic              wr_idx_o,
  output logic              wr_dat_o,
  output logic              rd_idx_o,
  output logic              rd_dat_o
);
  logic hit;

  always_comb begin
    hit      = bridge_cfg_i[EN_BIT] && (io_addr_i[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
    sel_o    = hit;
    wr_idx_o = hit && io_wr_i && !io_addr_i[0];
    wr_dat_o = hit && io_wr_i &&  io_addr_i[0];
    rd_idx_o = hit && io_rd_i && !io_addr_i[0];
    rd_dat_o = hit && io_rd_i &&  io_addr_i[0];
  end

  assert_one_target_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({wr_idx_o, wr_dat_o}) && $onehot0({rd_idx_o, rd_dat_o}));
  assert_off_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !bridge_cfg_i[EN_BIT] |-> !(wr_idx_o || wr_dat_o || rd_idx_o || rd_dat_o));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        wdata_i,
  output logic [IMG_W-1:0]  image_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (slot_is_ro(g)) begin : g_fixed
      assign image_o[g*BYTE_W +: BYTE_W] = slot_rst(g);
    end else begin : g_rw
      logic [7:0] val_q;
      logic [7:0] val_d;
      logic       load;

      always_comb begin
        load  = wr_en_i && (slot_i == SLOT_W'(g));
        val_d = (wdata_i & slot_and(g)) | slot_or(g);
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)  val_q <= slot_rst(g);
        else if (load) val_q <= val_d;
      end

      assign image_o[g*BYTE_W +: BYTE_W] = val_q;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h03F0,
  parameter int                EN_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [7:0]        bridge_cfg_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic [IMG_W-1:0]  cfg_image_o
);
  logic rst_n_s;
  logic sel, wr_idx, wr_dat, rd_idx, rd_dat;
  logic [7:0] idx_q, idx_d;
  logic [7:0] last_q, last_d;
  logic       idx_ok;
  logic [7:0] slot_val;
  logic [7:0] rd_val;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n_s)
  );

  cfg_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .EN_BIT(EN_BIT)) u_dec (
    .clk_i(clk_i), .rst_n_i(rst_n_s), .bridge_cfg_i(bridge_cfg_i),
    .io_addr_i(io_addr_i), .io_wr_i(io_wr_i), .io_rd_i(io_rd_i),
    .sel_o(sel), .wr_idx_o(wr_idx), .wr_dat_o(wr_dat),
    .rd_idx_o(rd_idx), .rd_dat_o(rd_dat)
  );

  always_comb idx_ok = (idx_q[7:5] == IDX_HI) && (int'(idx_q[4:0]) < NREG);

  cfg_reg_bank u_bank (
    .clk_i(clk_i), .rst_n_i(rst_n_s), .wr_en_i(wr_dat && idx_ok),
    .slot_i(idx_q[SLOT_W-1:0]), .wdata_i(io_wdata_i), .image_o(cfg_image_o)
  );

  always_comb begin
    slot_val = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (idx_q[SLOT_W-1:0] == SLOT_W'(i)) slot_val = cfg_image_o[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (rd_idx)      rd_val = idx_q;
    else if (rd_dat) rd_val = idx_ok ? slot_val : last_q;
    else             rd_val = 8'h00;
    io_rdata_o = rd_val;
  end

  always_comb begin
    idx_d  = wr_idx ? io_wdata_i : idx_q;
    last_d = last_q;
    if (wr_idx || wr_dat)      last_d = io_wdata_i;
    else if (rd_idx || rd_dat) last_d = rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q  <= 8'h00;
      last_q <= 8'h00;
    end else begin
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assert_idx_load_R2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wr_idx |=> idx_q == $past(io_wdata_i));
  assert_bad_idx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (wr_dat && !idx_ok) |=> $stable(cfg_image_o));
  assert_ro_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (wr_dat && ((idx_q == 8'hE0) || (idx_q == 8'hE1) || (idx_q == 8'hEC))) |=> $stable(cfg_image_o));
  assert_forced_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (wr_dat && idx_q == 8'hE5) |=> cfg_image_o[5*BYTE_W +: 2] == 2'b11);
  assert_idx_read_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    rd_idx |-> io_rdata_o == idx_q);
  assert_last_write_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (io_wr_i && sel) |=> last_q == $past(io_wdata_i));
  assert_off_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !bridge_cfg_i[EN_BIT] |-> io_rdata_o == 8'h00);
  assert_off_state_R10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !sel |=> $stable(cfg_image_o) && $stable(idx_q) && $stable(last_q));
endmodule

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
  localparam int NREG = 25;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]   bridge_cfg;
  logic [15:0]  addr;
  logic         wr, rd;
  logic [7:0]   wdata;
  logic [7:0]   rdata;
  logic [199:0] image;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_idx, m_last;
  logic [7:0] m_reg [NREG];

  always #2.5 clk = ~clk;

  cfg_index_port uut (
    .clk_i(clk), .rst_n_i(rst_n), .bridge_cfg_i(bridge_cfg),
    .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .cfg_image_o(image)
  );

  function automatic logic [7:0] shape(input int s, input logic [7:0] d);
    case (s)
      2:            return d & 8'hBF;
      3, 4:         return d & 8'hFC;
      5:            return d | 8'h03;
      7, 8, 20, 23: return d & 8'hFE;
      13:           return d & 8'h0F;
      15:           return d & 8'h7F;
      16:           return d & 8'hF4;
      17:           return d & 8'h3F;
      19:           return d & 8'hFB;
      22:           return d & 8'hF7;
      default:      return d;
    endcase
  endfunction

  function automatic bit valid(input logic [7:0] i);
    return (i >= 8'hE0) && (i <= 8'hF8);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_image(input string req);
    for (int k = 0; k < NREG; k++) begin
      if (image[k*8 +: 8] !== m_reg[k]) begin
        errors++;
        $display("FAIL %s: reg %02h actual=%02h expected=%02h", req, 8'hE0 + k, image[k*8 +: 8], m_reg[k]);
      end
    end
    checks++;
  endtask

  task automatic model_reset();
    m_idx = 8'h00; m_last = 8'h00;
    for (int k = 0; k < NREG; k++) m_reg[k] = 8'h00;
    m_reg[0] = 8'h3C; m_reg[2] = 8'h03;
  endtask

  // One bus cycle; models the expected result and checks the read bus and image.
  task automatic bus(input bit is_wr, input logic [15:0] a, input logic [7:0] d, input string req);
    bit en, hit;
    logic [7:0] exp;
    @(negedge clk);
    addr = a; wdata = d; wr = is_wr; rd = !is_wr;
    en  = bridge_cfg[1];
    hit = en && (a[15:1] == 15'h01F8);
    exp = 8'h00;
    if (hit && !is_wr) exp = !a[0] ? m_idx : (valid(m_idx) ? m_reg[m_idx[4:0]] : m_last);
    #1;
    if (!is_wr) check(req, rdata, exp);
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
    if (hit) begin
      if (is_wr) begin
        m_last = d;
        if (!a[0]) m_idx = d;
        else if (valid(m_idx) && !(m_idx inside {8'hE0, 8'hE1, 8'hEC}))
          m_reg[m_idx[4:0]] = shape(m_idx[4:0], d);
      end else begin
        m_last = exp;
      end
    end
    check_image(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bridge_cfg = 8'h02; addr = 16'h0; wr = 0; rd = 0; wdata = 0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_image("R1 reset image");
    check("R12 low byte is 0xE0", image[7:0], 8'h3C);
    bus(0, 16'h03F0, 8'h00, "R1 index resets to 0");
    bus(0, 16'h03F1, 8'h00, "R9 invalid read echoes last");

    bus(1, 16'h03F0, 8'hE5, "R2 load index");
    bus(0, 16'h03F0, 8'h00, "R7 index read");
    bus(1, 16'h03F1, 8'h00, "R6 forced high");
    bus(0, 16'h03F1, 8'h00, "R8 read E5 gives 03");
    for (int s = 0; s < NREG; s++) begin
      bus(1, 16'h03F0, 8'hE0 + s[7:0], "R2 select");
      bus(1, 16'h03F1, 8'hFF, "R6 mask ones");
      bus(0, 16'h03F1, 8'h00, "R8 R5 readback ones");
      bus(1, 16'h03F1, 8'h00, "R6 mask zeros");
      bus(0, 16'h03F1, 8'h00, "R3 readback zeros");
    end
    bus(1, 16'h03F0, 8'h10, "R2 invalid select");
    bus(1, 16'h03F1, 8'h5A, "R4 invalid write ignored");
    bus(0, 16'h03F1, 8'h00, "R9 echo of write");
    bus(1, 16'h03F0, 8'hF9, "R2 just past range");
    bus(0, 16'h03F1, 8'h00, "R9 echo of index write");
    bus(1, 16'h03F0, 8'hE2, "R2 select E2");
    bus(0, 16'h03F1, 8'h00, "R9 valid read recorded");
    bus(1, 16'h03F0, 8'hDF, "R2 just below range");
    bus(0, 16'h03F0, 8'h00, "R9 index read recorded");
    bus(0, 16'h03F1, 8'h00, "R9 echo of index read");
    bus(1, 16'h03F2, 8'hE3, "R11 off-address write");
    bus(0, 16'h03EF, 8'h00, "R11 off-address read");
    bridge_cfg = 8'hFD;
    bus(1, 16'h03F0, 8'hE3, "R10 disabled index write");
    bus(0, 16'h03F0, 8'h00, "R10 disabled read");
    bridge_cfg = 8'h02;
    bus(0, 16'h03F0, 8'h00, "R10 index kept");

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int r;
      r = $urandom_range(0, 99);
      bridge_cfg = (r < 8) ? 8'h00 : 8'h02;
      r = $urandom_range(0, 99);
      a = (r < 45) ? 16'h03F0 : (r < 92) ? 16'h03F1 : (r < 96) ? 16'h03F2 : 16'h03EF;
      d = $urandom_range(0, 255);
      if (a == 16'h03F0 && $urandom_range(0, 3) != 0) d = 8'hE0 + 8'($urandom_range(0, 24));
      bus($urandom_range(0, 1) == 1, a, d, "R3 R12 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule